// File: doc/BRIEF.md
# GPIO Port Register File with Masked Writes

This block is the software-visible state of one eight-pin general-purpose I/O port. It holds four writable per-pin registers (GPIO mode select, output enable, output level and interrupt enable) and one read-only register that returns the pad levels after a two-flop synchronizer. It drives the pad output-enable and output vectors, a per-pin GPIO-mode vector for the pin multiplexer and a per-pin interrupt-enable vector for the interrupt logic that sits next to it.

Each writable register can be reached at two addresses. The plain address loads all eight bits. The masked alias loads only the pins that the write selects, so software can change one pin without a read-modify-write sequence. In an alias write word the upper byte selects the pins and the lower byte gives their new levels. The bus side is a single-cycle synchronous register port: address, write strobe, write data and combinational read data.

Top module: `gpio_port_regs`

## Requirements
- R1: While rst_ni is low and after its release, every writable register is 0, so pad_oe_o, pad_out_o, gpio_en_o, irq_en_o and all register reads are 0.
- R2: A write to a plain address (mode 0x00, output enable 0x10, output 0x20, interrupt enable 0x50) loads wdata_i[7:0] into that register at the clock edge, ignores wdata_i[15:8], and no register changes in a cycle without a write.
- R3: A write to a masked alias (plain address plus 0x80: 0x80, 0x90, 0xA0, 0xD0) sets pin n of the register to wdata_i[n] when wdata_i[8+n] is 1 and leaves pin n unchanged when wdata_i[8+n] is 0.
- R4: A read of a masked alias returns the register value in rdata_o[7:0] and 0 in rdata_o[15:8].
- R5: pad_out_o equals the output register, gpio_en_o equals the mode register, and pad_oe_o[n] is 1 only when both mode bit n and output-enable bit n are 1.
- R6: A read of address 0x30 returns pad_i as sampled two clock edges earlier; writes to 0x30 change nothing.
- R7: Addresses not listed in R2, R3 and R6 (including 0x40, 0x60, 0x70, 0xB0, 0xF0 and any address with bits 3:0 nonzero) read as 0, and writes to them change nothing.
- R8: irq_en_o equals the interrupt-enable register and is 0 from reset until software writes it.
- R9: In a cycle that both writes and reads the same register, rdata_o shows the value before the write; the new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W (8) | Register byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 2*NPINS (16) | Write data; upper byte is the pin mask for alias writes |
| rdata_o | output | 2*NPINS (16) | Read data for addr_i, combinational |
| pad_i | input | NPINS (8) | Pad input levels, asynchronous |
| pad_oe_o | output | NPINS (8) | Pad output enable |
| pad_out_o | output | NPINS (8) | Pad output level |
| gpio_en_o | output | NPINS (8) | Per-pin GPIO mode select to the pin multiplexer |
| irq_en_o | output | NPINS (8) | Per-pin interrupt enable |

## Verification
A register write and a read of the same register fall in the same cycle whenever the write strobe is high, since the read port always decodes addr_i; likewise a write to the input register coincides with fresh pad samples entering the synchronizer. The bench provokes both by issuing writes to every mapped and unmapped address, plain and aliased, while changing pad_i on most cycles. Read data is judged one nanosecond before each rising edge against a behavioural model still holding the pre-write state, and the model's two-deep sample history decides what the input register must show.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MODE,
    SEL_OE,
    SEL_OUT,
    SEL_IN,
    SEL_IE
  } reg_sel_e;

  localparam int NUM_RW = 4;

  // writable register slot -> decoded select
  function automatic reg_sel_e rw_sel(input int idx);
    case (idx)
      0:       return SEL_MODE;
      1:       return SEL_OE;
      2:       return SEL_OUT;
      default: return SEL_IE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ALIAS_BIT = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic              alias_o
);

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-5:0] slot;

  always_comb begin
    rel            = addr_i;
    rel[ALIAS_BIT] = 1'b0;
    slot           = rel[ADDR_W-1:4];
    alias_o        = addr_i[ALIAS_BIT];
    sel_o          = SEL_NONE;
    if (rel[3:0] == 4'h0) begin
      case (slot)
        (ADDR_W-4)'(0): sel_o = SEL_MODE;
        (ADDR_W-4)'(1): sel_o = SEL_OE;
        (ADDR_W-4)'(2): sel_o = SEL_OUT;
        (ADDR_W-4)'(3): sel_o = alias_o ? SEL_NONE : SEL_IN;
        (ADDR_W-4)'(5): sel_o = SEL_IE;
        default:        sel_o = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= (q_o & ~mask_i) | (val_i & mask_i);
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int ADDR_W      = 8,
  parameter int ALIAS_BIT   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_i,
  input  logic [2*NPINS-1:0]   wdata_i,
  output logic [2*NPINS-1:0]   rdata_o,
  input  logic [NPINS-1:0]     pad_i,
  output logic [NPINS-1:0]     pad_oe_o,
  output logic [NPINS-1:0]     pad_out_o,
  output logic [NPINS-1:0]     gpio_en_o,
  output logic [NPINS-1:0]     irq_en_o
);

  localparam int DW = 2 * NPINS;

  reg_sel_e         sel;
  logic             is_alias;
  logic [NPINS-1:0] wr_mask;
  logic [NPINS-1:0] rw_q [NUM_RW];
  logic [NPINS-1:0] in_q;

  gpio_addr_dec #(
    .ADDR_W    (ADDR_W),
    .ALIAS_BIT (ALIAS_BIT)
  ) dec_i (
    .addr_i  (addr_i),
    .sel_o   (sel),
    .alias_o (is_alias)
  );

  // plain write loads every pin, alias write takes the upper half as mask
  assign wr_mask = is_alias ? wdata_i[DW-1:NPINS] : '1;

  for (genvar i = 0; i < NUM_RW; i++) begin : g_reg
    gpio_mask_reg #(.W(NPINS)) reg_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (we_i && (sel == rw_sel(i))),
      .mask_i (wr_mask),
      .val_i  (wdata_i[NPINS-1:0]),
      .q_o    (rw_q[i])
    );
  end

  gpio_in_sync #(
    .W      (NPINS),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (in_q)
  );

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_MODE: rdata_o[NPINS-1:0] = rw_q[0];
      SEL_OE:   rdata_o[NPINS-1:0] = rw_q[1];
      SEL_OUT:  rdata_o[NPINS-1:0] = rw_q[2];
      SEL_IN:   rdata_o[NPINS-1:0] = in_q;
      SEL_IE:   rdata_o[NPINS-1:0] = rw_q[3];
      default:  rdata_o = '0;
    endcase
  end

  assign gpio_en_o = rw_q[0];
  assign pad_oe_o  = rw_q[0] & rw_q[1];
  assign pad_out_o = rw_q[2];
  assign irq_en_o  = rw_q[3];

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
  parameter int NPINS     = 8,
  parameter int ADDR_W    = 8,
  parameter int ALIAS_BIT = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               we_i,
  input logic [2*NPINS-1:0] wdata_i,
  input logic [2*NPINS-1:0] rdata_o,
  input logic [NPINS-1:0]   pad_oe_o,
  input logic [NPINS-1:0]   pad_out_o,
  input logic [NPINS-1:0]   gpio_en_o,
  input logic [NPINS-1:0]   irq_en_o
);

  localparam logic [ADDR_W-1:0] A_OUT     = ADDR_W'(32'h20);
  localparam logic [ADDR_W-1:0] A_OUT_MSK = ADDR_W'((32'h1 << ALIAS_BIT) | 32'h20);

  assert_plain_out_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_OUT) |=> pad_out_o == $past(wdata_i[NPINS-1:0]));

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(pad_out_o) && $stable(gpio_en_o) && $stable(irq_en_o) && $stable(pad_oe_o)));

  assert_masked_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_OUT_MSK) |=>
      ((pad_out_o ^ $past(pad_out_o)) & ~$past(wdata_i[2*NPINS-1:NPINS])) == '0);

  assert_masked_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_OUT_MSK) |=>
      ((pad_out_o ^ $past(wdata_i[NPINS-1:0])) & $past(wdata_i[2*NPINS-1:NPINS])) == '0);

  assert_alias_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i[ALIAS_BIT] |-> rdata_o[2*NPINS-1:NPINS] == '0);

  assert_oe_needs_mode_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~gpio_en_o) == '0);

  assert_unaligned_reads_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[3:0] != 4'h0) |-> rdata_o == '0);

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
  .NPINS     (NPINS),
  .ADDR_W    (ADDR_W),
  .ALIAS_BIT (ALIAS_BIT)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pad_oe_o  (pad_oe_o),
  .pad_out_o (pad_out_o),
  .gpio_en_o (gpio_en_o),
  .irq_en_o  (irq_en_o)
);

// File: tb/gpio_port_regs_tb_top.sv
module gpio_port_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        we;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [7:0]  pad, pad_oe, pad_out, gpio_en, irq_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // behavioural reference state
  logic [7:0] m_mode = '0, m_oe = '0, m_out = '0, m_ie = '0;
  logic [7:0] m_hist [$];

  always #2 clk = ~clk;

  gpio_port_regs dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .addr_i    (addr),
    .we_i      (we),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .pad_i     (pad),
    .pad_oe_o  (pad_oe),
    .pad_out_o (pad_out),
    .gpio_en_o (gpio_en),
    .irq_en_o  (irq_en)
  );

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] m_read(logic [7:0] a);
    logic [7:0] rel = a & 8'h7f;
    if (rel[3:0] != 4'h0) return 16'h0;
    case (rel[6:4])
      3'd0: return {8'h0, m_mode};
      3'd1: return {8'h0, m_oe};
      3'd2: return {8'h0, m_out};
      3'd3: return a[7] ? 16'h0 : {8'h0, m_hist[0]};
      3'd5: return {8'h0, m_ie};
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [7:0] merge(logic [7:0] old, logic [7:0] a, logic [15:0] d);
    logic [7:0] m = a[7] ? d[15:8] : 8'hff;
    return (old & ~m) | (d[7:0] & m);
  endfunction

  task automatic m_write(logic [7:0] a, logic [15:0] d);
    logic [7:0] rel = a & 8'h7f;
    if (rel[3:0] != 4'h0) return;
    case (rel[6:4])
      3'd0: m_mode = merge(m_mode, a, d);
      3'd1: m_oe   = merge(m_oe, a, d);
      3'd2: m_out  = merge(m_out, a, d);
      3'd5: m_ie   = merge(m_ie, a, d);
      default: ;
    endcase
  endtask

  function automatic string tag_of(logic [7:0] a);
    logic [7:0] rel = a & 8'h7f;
    if (rel[3:0] != 4'h0) return "R7";
    case (rel[6:4])
      3'd0, 3'd1, 3'd2, 3'd5: return a[7] ? "R4" : "R2";
      3'd3: return a[7] ? "R7" : "R6";
      default: return "R7";
    endcase
  endfunction

  // one bus cycle: drive at negedge, judge just before the rising edge
  task automatic cyc(bit w, logic [7:0] a, logic [15:0] d, logic [7:0] p, string tag);
    @(negedge clk);
    we = w; addr = a; wdata = d; pad = p;
    #1;
    chk(tag, "rdata", rdata, m_read(a));
    chk("R5", "pad_oe", {8'h0, pad_oe}, {8'h0, m_mode & m_oe});
    chk("R5", "pad_out", {8'h0, pad_out}, {8'h0, m_out});
    chk("R5", "gpio_en", {8'h0, gpio_en}, {8'h0, m_mode});
    chk("R8", "irq_en", {8'h0, irq_en}, {8'h0, m_ie});
    @(posedge clk);
    if (w) m_write(a, d);
    void'(m_hist.pop_front());
    m_hist.push_back(p);
  endtask

  task automatic rd(logic [7:0] a, string tag);
    cyc(1'b0, a, 16'h0, pad, tag);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] addrs [14] = '{8'h00, 8'h10, 8'h20, 8'h30, 8'h50, 8'h80, 8'h90,
                               8'ha0, 8'hd0, 8'h40, 8'h70, 8'hb0, 8'h24, 8'hf0};
    m_hist.push_back(8'h0);
    m_hist.push_back(8'h0);
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; pad = 8'h5a;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      addr = 8'h20;
      #1;
      chk("R1", "reset pad_oe", {8'h0, pad_oe}, 16'h0);
      chk("R1", "reset pad_out", {8'h0, pad_out}, 16'h0);
      chk("R1", "reset rdata", rdata, 16'h0);
      chk("R8", "reset irq_en", {8'h0, irq_en}, 16'h0);
    end
    @(negedge clk);
    pad = 8'h00;
    rst_n = 1'b1;

    // R1: all registers read zero after release
    rd(8'h00, "R1"); rd(8'h10, "R1"); rd(8'h50, "R1"); rd(8'h30, "R1");

    // R2: plain writes, upper byte ignored; R9: read of old value in the write cycle
    cyc(1'b1, 8'h00, 16'hffa5, 8'h00, "R9");
    cyc(1'b1, 8'h10, 16'h3c3c, 8'h00, "R9");
    cyc(1'b1, 8'h20, 16'hf00f, 8'h00, "R9");
    cyc(1'b1, 8'h50, 16'h0081, 8'h00, "R9");
    rd(8'h00, "R2"); rd(8'h10, "R2"); rd(8'h20, "R2"); rd(8'h50, "R2");

    // R3: masked writes (partial, empty and full mask), then R4 alias reads
    cyc(1'b1, 8'ha0, 16'h3caa, 8'h00, "R3");
    rd(8'h20, "R3");
    cyc(1'b1, 8'ha0, 16'h00ff, 8'h00, "R3");
    rd(8'h20, "R3");
    cyc(1'b1, 8'h80, 16'hff0f, 8'h00, "R3");
    cyc(1'b1, 8'h90, 16'h8181, 8'h00, "R3");
    cyc(1'b1, 8'hd0, 16'h0300, 8'h00, "R3");
    rd(8'ha0, "R4"); rd(8'h80, "R4"); rd(8'h90, "R4"); rd(8'hd0, "R4");

    // R6: pad levels through the synchronizer, writes to the input register ignored
    for (int i = 0; i < 8; i++) cyc(1'b0, 8'h30, 16'h0, 8'(i * 37 + 1), "R6");
    cyc(1'b1, 8'h30, 16'hffff, 8'hc3, "R6");
    cyc(1'b1, 8'hb0, 16'hffff, 8'h3c, "R7");
    rd(8'h30, "R6"); rd(8'h30, "R6"); rd(8'h30, "R6");

    // R7: unmapped writes and reads
    cyc(1'b1, 8'h40, 16'hffff, 8'h00, "R7");
    cyc(1'b1, 8'h60, 16'hffff, 8'h00, "R7");
    cyc(1'b1, 8'h70, 16'hffff, 8'h00, "R7");
    cyc(1'b1, 8'h24, 16'hffff, 8'h00, "R7");
    cyc(1'b1, 8'hf0, 16'hffff, 8'h00, "R7");
    rd(8'h40, "R7"); rd(8'h24, "R7"); rd(8'h20, "R7"); rd(8'h00, "R7");

    // mixed traffic with pads toggling
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a = addrs[$urandom_range(0, 13)];
      bit w = ($urandom_range(0, 2) != 0);
      cyc(w, a, 16'($urandom()), 8'($urandom()), w ? "R9" : tag_of(a));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule